// File: doc/BRIEF.md
# Set-Associative Page Translation Buffer

This block translates a 32-bit virtual address into a physical address and a set of access rights, using a small set-associative array of cached page translations. Pages are 4 KiB. The low 12 address bits pass through unchanged as the page offset. The bits above them form the virtual page number, and the low bits of that number select one set. Every way of the selected set is compared at once. An entry matches when its stored page number equals the lookup page number and either the entry is marked as shared by all processes or its stored process number equals the caller's.

The caller drives an address and a process number and reads the result in the same cycle. Entries are installed through a single write port. The port takes a way, a set index, a packed tag word and a packed data word, and the write lands on the next rising clock edge. The number of ways, the number of sets and the width of the process number are parameters.

Top module: `page_xlat_tlb`

## Requirements
- R1: The page number is `lk_vaddr[31:12]`. The set is its low log2(SETS) bits, so an entry written at index k is seen only by addresses whose page number ends in k.
- R2: Tag word layout: page number in [31:12], shared-by-all flag in bit 11, valid flag in bit 10, process number in bits [PID_W-1:0]. The valid flag is stored but is not consulted by the match.
- R3: An entry hits when its page number equals the lookup page number and either its shared flag is 1 or its process number equals `lk_pid`.
- R4: An entry whose page number differs from the lookup page number never hits, whatever its flags.
- R5: An entry with the shared flag 0 and a process number different from `lk_pid` does not hit.
- R6: On a hit, `lk_paddr` is the frame number of the winning entry in [31:12], with `lk_vaddr[11:0]` in [11:0].
- R7: Data word layout: frame number in [19:0], execute in bit 21, write in bit 22, read in bit 23, cacheable in bit 24. Outputs `lk_rd`, `lk_wr` and `lk_ex` copy bits 23, 22 and 21 of the winning entry.
- R8: When several ways of the set hit, the lowest-numbered way supplies the result.
- R9: On a miss, `lk_hit`, `lk_rd`, `lk_wr`, `lk_ex` are 0 and `lk_paddr` is 0.
- R10: The lookup is combinational over the stored array. A write changes the lookup result only after the rising edge on which `wr_en` is sampled high, and with no write and steady inputs the result holds.
- R11: Reset clears every tag and data word to zero. A page-0 lookup with process number 0 then hits with frame 0 and no rights, and any other process number misses.
- R12: A write replaces only the entry at (`wr_way`, `wr_idx`). The other ways of that set keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | PID_W | Current process number |
| lk_hit | output | 1 | Some way of the set matched |
| lk_paddr | output | 32 | Translated physical address |
| lk_rd | output | 1 | Read allowed |
| lk_wr | output | 1 | Write allowed |
| lk_ex | output | 1 | Execute allowed |
| wr_en | input | 1 | Install an entry on this edge |
| wr_way | input | WAY_W | Way to write |
| wr_idx | input | IDX_W | Set to write |
| wr_tag | input | 32 | Packed tag word |
| wr_data | input | 32 | Packed data word |

## Verification
The bench builds the block with four ways, four sets and a 6-bit process number. With only four sets, pages 1 and 5 land in the same set, and a page that shares an index with a stored entry but differs in its upper bits tests the full page-number compare. Four ways let two shared entries for one page sit in ways 1 and 3, so lowest-way priority is visible. Rewriting way 1 then exposes way 3 without disturbing it. The 6-bit process number leaves unused tag bits between the process field and the valid flag, and the bench sets those bits to show they have no effect.

// File: rtl/page_xlat_tlb.sv
module page_xlat_tlb #(
  parameter int WAYS  = 4,
  parameter int SETS  = 16,
  parameter int PID_W = 8,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       lk_vaddr,
  input  logic [PID_W-1:0]  lk_pid,
  output logic              lk_hit,
  output logic [31:0]       lk_paddr,
  output logic              lk_rd,
  output logic              lk_wr,
  output logic              lk_ex,
  input  logic              wr_en,
  input  logic [WAY_W-1:0]  wr_way,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_tag,
  input  logic [31:0]       wr_data
);

  localparam logic [31:0] DATA_KEEP = 32'h01EF_FFFF;

  logic [31:0] tag_q  [WAYS][SETS];
  logic [31:0] data_q [WAYS][SETS];

  logic [19:0]      vpn;
  logic [IDX_W-1:0] idx;
  logic [WAYS-1:0]  way_hit;
  logic [31:0]      sel_data;
  logic             any_hit;

  assign vpn = lk_vaddr[31:12];
  assign idx = vpn[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          tag_q[w][s]  <= '0;
          data_q[w][s] <= '0;
        end
    end else if (wr_en) begin
      tag_q[wr_way][wr_idx]  <= wr_tag;
      data_q[wr_way][wr_idx] <= wr_data & DATA_KEEP;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [31:0] t;
    assign t = tag_q[w][idx];
    assign way_hit[w] = (t[31:12] == vpn) && (t[11] || (t[PID_W-1:0] == lk_pid));
  end

  always_comb begin
    any_hit  = 1'b0;
    sel_data = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (way_hit[w]) begin
        any_hit  = 1'b1;
        sel_data = data_q[w][idx];
      end
    end
  end

  assign lk_hit   = any_hit;
  assign lk_paddr = any_hit ? {sel_data[19:0], lk_vaddr[11:0]} : 32'h0;
  assign lk_rd    = sel_data[23];
  assign lk_wr    = sel_data[22];
  assign lk_ex    = sel_data[21];

  logic unused_bits;
  assign unused_bits = ^{sel_data[31:24], sel_data[20]};

endmodule

// File: rtl/page_xlat_tlb_chk.sv
module page_xlat_tlb_chk #(
  parameter int PID_W = 8,
  parameter int IDX_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       lk_vaddr,
  input logic [PID_W-1:0]  lk_pid,
  input logic              lk_hit,
  input logic [31:0]       lk_paddr,
  input logic              lk_rd,
  input logic              lk_wr,
  input logic              lk_ex,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [31:0]       wr_tag
);

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;

  p_miss_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_paddr == 32'h0 && !lk_rd && !lk_wr && !lk_ex));

  p_offset_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[11:0] == lk_vaddr[11:0]));

  p_shared_fill_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && $past(wr_en) && $past(wr_tag[11]) &&
     $past(wr_idx) == lk_vaddr[12 +: IDX_W] &&
     $past(wr_tag[31:12]) == lk_vaddr[31:12]) |-> lk_hit);

  p_result_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !$past(wr_en) && $stable(lk_vaddr) && $stable(lk_pid))
      |-> ($stable(lk_hit) && $stable(lk_paddr) && $stable({lk_rd, lk_wr, lk_ex})));

  logic unused_pid;
  assign unused_pid = ^lk_pid;

endmodule

bind page_xlat_tlb page_xlat_tlb_chk #(.PID_W(PID_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
  .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_rd(lk_rd), .lk_wr(lk_wr),
  .lk_ex(lk_ex), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag)
);

// File: tb/sim_page_xlat_tlb.sv
module sim_page_xlat_tlb;
  localparam int WAYS = 4, SETS = 4, PID_W = 6;
  localparam int IDX_W = 2, WAY_W = 2;

  logic clk = 0, rst_n = 0;
  logic [31:0] lk_vaddr = 0;
  logic [PID_W-1:0] lk_pid = 0;
  logic lk_hit, lk_rd, lk_wr, lk_ex;
  logic [31:0] lk_paddr;
  logic wr_en = 0;
  logic [WAY_W-1:0] wr_way = 0;
  logic [IDX_W-1:0] wr_idx = 0;
  logic [31:0] wr_tag = 0, wr_data = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  page_xlat_tlb #(.WAYS(WAYS), .SETS(SETS), .PID_W(PID_W)) u0 (
    .clk(clk), .rst_n(rst_n), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid),
    .lk_hit(lk_hit), .lk_paddr(lk_paddr), .lk_rd(lk_rd), .lk_wr(lk_wr),
    .lk_ex(lk_ex), .wr_en(wr_en), .wr_way(wr_way), .wr_idx(wr_idx),
    .wr_tag(wr_tag), .wr_data(wr_data));

  // {vaddr, pid, hit, paddr, {r,w,x}}
  localparam logic [73:0] VEC [0:8] = '{
    {32'h0000_1ABC, 6'd5,  1'b1, 32'h1234_5ABC, 3'b101}, // R3 R7 own pid
    {32'h0000_1ABC, 6'd6,  1'b0, 32'h0000_0000, 3'b000}, // R5 R9 other pid
    {32'h0000_2010, 6'd9,  1'b1, 32'hABCD_E010, 3'b010}, // R3 shared
    {32'h0000_5FFF, 6'd7,  1'b1, 32'h0007_7FFF, 3'b111}, // R1 same set as page 1
    {32'h0000_9123, 6'd5,  1'b0, 32'h0000_0000, 3'b000}, // R4 index match, page differs
    {32'h0000_3456, 6'd0,  1'b1, 32'h1111_1456, 3'b010}, // R8 way1 beats way3
    {32'h0000_A00C, 6'd1,  1'b1, 32'h00A0_A00C, 3'b100}, // R2 valid flag clear still hits
    {32'h0000_6000, 6'd7,  1'b0, 32'h0000_0000, 3'b000}, // R4 empty page
    {32'h0000_8ABC, 6'd2,  1'b1, 32'h0000_0ABC, 3'b000}  // R2 middle tag bits ignored
  };

  task automatic put(input int way, input int idx, input logic [31:0] t, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_way = way[WAY_W-1:0]; wr_idx = idx[IDX_W-1:0]; wr_tag = t; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look(input logic [31:0] va, input logic [PID_W-1:0] pid);
    @(negedge clk);
    lk_vaddr = va; lk_pid = pid;
    #2;
  endtask

  task automatic expect_out(input string req, input logic h, input logic [31:0] pa, input logic [2:0] perm);
    checks++;
    if (lk_hit !== h || lk_paddr !== pa || {lk_rd, lk_wr, lk_ex} !== perm) begin
      fails++;
      $display("FAIL %s: got hit=%b pa=%h rwx=%b, want hit=%b pa=%h rwx=%b",
               req, lk_hit, lk_paddr, {lk_rd, lk_wr, lk_ex}, h, pa, perm);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;

    look(32'h0000_0123, 6'd0); expect_out("R11 page0 pid0", 1'b1, 32'h0000_0123, 3'b000);
    look(32'h0000_0123, 6'd1); expect_out("R11 page0 pid1", 1'b0, 32'h0, 3'b000);
    look(32'h0000_4000, 6'd0); expect_out("R11 page4", 1'b0, 32'h0, 3'b000);

    put(0, 1, 32'h0000_1405, 32'h00A1_2345);
    put(1, 2, 32'h0000_2C03, 32'h004A_BCDE);
    put(2, 1, 32'h0000_5407, 32'h00E0_0077);
    put(3, 3, 32'h0000_3C00, 32'h0083_3333);
    put(1, 3, 32'h0000_3C00, 32'h0041_1111);
    put(2, 2, 32'h0000_A001, 32'h0080_0A0A);
    put(3, 0, 32'h0000_83C2, 32'h0000_0000);

    for (int i = 0; i < 9; i++) begin
      look(VEC[i][73:42], VEC[i][41:36]);
      expect_out($sformatf("R3/R4/R5/R6/R7/R8 vector %0d", i),
                 VEC[i][35], VEC[i][34:3], VEC[i][2:0]);
    end

    // R10: write visible only after the edge
    @(negedge clk);
    lk_vaddr = 32'h0000_C321; lk_pid = 6'd2;
    wr_en = 1; wr_way = 0; wr_idx = 0; wr_tag = 32'h0000_C002; wr_data = 32'h0080_0042;
    #2; expect_out("R10 before edge", 1'b0, 32'h0, 3'b000);
    @(negedge clk); wr_en = 0;
    #2; expect_out("R10 after edge", 1'b1, 32'h0004_2321, 3'b100);

    // R12: rewrite way1 set3, way3 now wins for page 3
    put(1, 3, 32'h0000_7C00, 32'h0020_0001);
    look(32'h0000_3456, 6'd0); expect_out("R12 way3 kept", 1'b1, 32'h3333_3456, 3'b100);
    look(32'h0000_7004, 6'd0); expect_out("R12 way1 new", 1'b1, 32'h0000_1004, 3'b001);
    look(32'h0000_1ABC, 6'd5); expect_out("R12 other set kept", 1'b1, 32'h1234_5ABC, 3'b101);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule